// File: doc/BRIEF.md
# PHY P3 Clock-State Controller

This block sequences a PIPE PHY into and out of its deepest power state, P3, in which the PHY stops its PCLK. It runs on an always-on clock, so it keeps working while PCLK is absent. The link layer asks for P3 entry or exit with single-cycle requests. The controller drives the PHY PowerDown code and waits for the PHY to acknowledge each change on PhyStatus. It publishes a flag that tells downstream clock gating, and the rest of the controller, whether PCLK may be treated as running.

A six-step handshake marks PCLK as stopped only after the PHY confirms P3. It marks PCLK as running again only after the PHY confirms the exit. PhyStatus comes from the PHY's clock domain. It passes through a synchronizer, and a rising-edge detector turns it into a one-cycle acknowledge. An exit request that arrives while entry is still in progress is remembered and carried out as soon as P3 is reached. The 3-bit step code is exported for debug.

Top module: `p3clk_ctrl`

## Requirements
- R1: After reset, clk_state is 0 (normal), phy_powerdown is 2 (P2) and pclk_running is 1. PowerDown codes are 0=P0, 1=P1, 2=P2, 3=P3.
- R2: In state 0, a p3_enter_req moves the block to state 1 (entry request) with phy_powerdown 3 at the next edge. State 1 lasts exactly one cycle and is followed by state 2 (wait for entry acknowledge).
- R3: State 2 is held until a rising edge of phy_status_in has passed the synchronizer. With the default two stages, state 3 appears on the third rising clock edge after phy_status_in goes high, and not before.
- R4: In state 3 (in P3), pclk_running is 0 and p3_enter_req has no effect.
- R5: In state 3, a p3_exit_req moves the block to state 4 (exit request) at the next edge, with phy_powerdown set to the requested exit value. State 4 lasts one cycle and is followed by state 5 (wait for exit acknowledge).
- R6: State 5 returns to state 0 on the third rising edge after a new rising edge of phy_status_in. The exit PowerDown value is kept.
- R7: pclk_running is 0 exactly while clk_state is 3 or 4, and 1 in every other state, including 5.
- R8: A p3_exit_req seen in state 1 or 2 is held, together with the exit_pd_sel value present at that moment. The first such request wins. On reaching state 3, the block moves on to state 4 at the next edge without a new request.
- R9: The exit PowerDown value is exit_pd_sel, except that a selection of 3 (P3) is replaced by 0 (P0).
- R10: p3_exit_req is ignored in states 0 and 5, and p3_enter_req is ignored outside state 0. A PhyStatus pulse outside states 2 and 5 changes nothing.
- R11: Only a rising edge of PhyStatus counts as an acknowledge. A PhyStatus level left high since entry does not complete an exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p3_enter_req | input | 1 | One-cycle P3 entry request |
| p3_exit_req | input | 1 | One-cycle P3 exit request |
| exit_pd_sel | input | 2 | PowerDown code to use on exit |
| phy_status_in | input | 1 | PhyStatus from the PHY (asynchronous) |
| phy_powerdown | output | 2 | PowerDown code driven to the PHY |
| pclk_running | output | 1 | High while PCLK may be assumed running |
| clk_state | output | 3 | Debug step code, 0 to 5 |

## Verification
The properties assume that request inputs are one-cycle pulses. They also assume that the PHY raises PhyStatus only in answer to a request and keeps it high for at least one always-on cycle, so that no acknowledge arrives during the one-cycle request steps. The stimulus never raises PhyStatus during states 1 and 4. The only exceptions are deliberate pulses in states where the status is to be ignored. Each raise is held for several cycles so that it crosses the synchronizer. The sweep covers every exit selection against each point at which the exit can be requested.

// File: rtl/p3clk_pkg.sv
package p3clk_pkg;
    localparam int PD_W = 2;
    localparam int ST_W = 3;

    localparam logic [PD_W-1:0] PD_P0 = 2'd0;
    localparam logic [PD_W-1:0] PD_P2 = 2'd2;
    localparam logic [PD_W-1:0] PD_P3 = 2'd3;

    typedef enum logic [ST_W-1:0] {
        CS_NORM       = 3'd0,
        CS_ENTER      = 3'd1,
        CS_ENTER_WAIT = 3'd2,
        CS_SLEEP      = 3'd3,
        CS_EXIT       = 3'd4,
        CS_EXIT_WAIT  = 3'd5
    } clk_state_e;

    typedef struct packed {
        clk_state_e      state;
        logic [PD_W-1:0] pd;
        logic            run;
    } fsm_regs_t;

    typedef struct packed {
        logic            pend;
        logic [PD_W-1:0] pd;
    } hold_regs_t;

    // A request for P3 as the exit level falls back to P0
    function automatic logic [PD_W-1:0] map_exit_pd(input logic [PD_W-1:0] sel);
        return (sel == PD_P3) ? PD_P0 : sel;
    endfunction
endpackage

// File: rtl/p3clk_sync.sv
module p3clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
    end

    for (genvar i = 1; i < CHAIN_W; i++) begin : g_chain
        always_comb begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/p3clk_exit_hold.sv
module p3clk_exit_hold
    import p3clk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [PD_W-1:0] sel_in,
    input  logic            clear,
    output logic            pending,
    output logic [PD_W-1:0] pend_pd
);
    hold_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.pend = 1'b0;
        end else if (capture && !r_q.pend) begin
            r_d.pend = 1'b1;
            r_d.pd   = map_exit_pd(sel_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{pend: 1'b0, pd: PD_P0};
        else        r_q <= r_d;
    end

    assign pending = r_q.pend;
    assign pend_pd = r_q.pd;
endmodule

// File: rtl/p3clk_fsm.sv
module p3clk_fsm
    import p3clk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter_req,
    input  logic            exit_req,
    input  logic [PD_W-1:0] exit_sel,
    input  logic            ack,
    input  logic            pending,
    input  logic [PD_W-1:0] pend_pd,
    output logic            capture,
    output logic            clear,
    output clk_state_e      state,
    output logic [PD_W-1:0] pd,
    output logic            run
);
    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        capture = 1'b0;
        clear   = 1'b0;
        unique case (r_q.state)
            CS_NORM: begin
                if (enter_req) begin
                    r_d.state = CS_ENTER;
                    r_d.pd    = PD_P3;
                end
            end
            CS_ENTER: begin
                capture   = exit_req;
                r_d.state = CS_ENTER_WAIT;
            end
            CS_ENTER_WAIT: begin
                capture = exit_req;
                if (ack) r_d.state = CS_SLEEP;
            end
            CS_SLEEP: begin
                if (pending) begin
                    clear     = 1'b1;
                    r_d.state = CS_EXIT;
                    r_d.pd    = pend_pd;
                end else if (exit_req) begin
                    r_d.state = CS_EXIT;
                    r_d.pd    = map_exit_pd(exit_sel);
                end
            end
            CS_EXIT: begin
                r_d.state = CS_EXIT_WAIT;
            end
            CS_EXIT_WAIT: begin
                if (ack) r_d.state = CS_NORM;
            end
            default: begin
                r_d.state = CS_NORM;
            end
        endcase
        r_d.run = !((r_d.state == CS_SLEEP) || (r_d.state == CS_EXIT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: CS_NORM, pd: PD_P2, run: 1'b1};
        else        r_q <= r_d;
    end

    assign state = r_q.state;
    assign pd    = r_q.pd;
    assign run   = r_q.run;
endmodule

// File: rtl/p3clk_ctrl.sv
module p3clk_ctrl
    import p3clk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk_aon,
    input  logic            rst_n,
    input  logic            p3_enter_req,
    input  logic            p3_exit_req,
    input  logic [PD_W-1:0] exit_pd_sel,
    input  logic            phy_status_in,
    output logic [PD_W-1:0] phy_powerdown,
    output logic            pclk_running,
    output logic [ST_W-1:0] clk_state
);
    logic            ack;
    logic            capture;
    logic            clear;
    logic            pending;
    logic [PD_W-1:0] pend_pd;
    clk_state_e      state;

    p3clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk_aon),
        .rst_n      (rst_n),
        .async_in   (phy_status_in),
        .rise_pulse (ack)
    );

    p3clk_exit_hold u_hold (
        .clk     (clk_aon),
        .rst_n   (rst_n),
        .capture (capture),
        .sel_in  (exit_pd_sel),
        .clear   (clear),
        .pending (pending),
        .pend_pd (pend_pd)
    );

    p3clk_fsm u_fsm (
        .clk       (clk_aon),
        .rst_n     (rst_n),
        .enter_req (p3_enter_req),
        .exit_req  (p3_exit_req),
        .exit_sel  (exit_pd_sel),
        .ack       (ack),
        .pending   (pending),
        .pend_pd   (pend_pd),
        .capture   (capture),
        .clear     (clear),
        .state     (state),
        .pd        (phy_powerdown),
        .run       (pclk_running)
    );

    assign clk_state = state;
endmodule

// File: rtl/p3clk_ctrl_chk.sv
module p3clk_ctrl_chk (
    input logic       clk_aon,
    input logic       rst_n,
    input logic       p3_enter_req,
    input logic [2:0] clk_state,
    input logic [1:0] phy_powerdown,
    input logic       pclk_running
);
    // R2
    enter_step_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        (clk_state == 3'd0 && p3_enter_req) |=> (clk_state == 3'd1 && phy_powerdown == 2'd3));

    // R2
    enter_to_wait_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        (clk_state == 3'd1) |=> (clk_state == 3'd2));

    // R2
    legal_code_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        clk_state <= 3'd5);

    // R3
    sleep_from_wait_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        (clk_state == 3'd3 && $past(clk_state) != 3'd3) |-> ($past(clk_state) == 3'd2));

    // R5
    exit_to_wait_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        (clk_state == 3'd4) |=> (clk_state == 3'd5));

    // R7
    run_fall_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        $fell(pclk_running) |-> (clk_state == 3'd3));

    // R7
    run_rise_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        $rose(pclk_running) |-> (clk_state == 3'd5));

    // R9
    exit_level_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        (clk_state == 3'd4) |-> (phy_powerdown != 2'd3));
endmodule

bind p3clk_ctrl p3clk_ctrl_chk u_chk (
    .clk_aon       (clk_aon),
    .rst_n         (rst_n),
    .p3_enter_req  (p3_enter_req),
    .clk_state     (clk_state),
    .phy_powerdown (phy_powerdown),
    .pclk_running  (pclk_running)
);

// File: tb/tb_p3clk_ctrl.sv
`timescale 1ns/1ps
module tb_p3clk_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enter = 1'b0;
    logic       exitr = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       status = 1'b0;
    logic [1:0] pd;
    logic       run;
    logic [2:0] st;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    p3clk_ctrl dut (
        .clk_aon       (clk),
        .rst_n         (rst_n),
        .p3_enter_req  (enter),
        .p3_exit_req   (exitr),
        .exit_pd_sel   (sel),
        .phy_status_in (status),
        .phy_powerdown (pd),
        .pclk_running  (run),
        .clk_state     (st)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 state", st, 0);
        chk("R1 powerdown", pd, 2);
        chk("R1 run", run, 1);

        // R10: exit request and status pulse in normal state change nothing
        exitr = 1'b1; sel = 2'd1;
        step(1);
        exitr = 1'b0;
        chk("R10 exit in normal state", st, 0);
        chk("R10 exit in normal pd", pd, 2);
        status = 1'b1;
        step(4);
        status = 1'b0;
        chk("R10 status in normal", st, 0);
        step(3);

        for (int mode = 0; mode < 3; mode++) begin
            for (int s = 0; s < 4; s++) begin
                int exp_pd;
                exp_pd = (s == 3) ? 0 : s;

                enter = 1'b1;
                step(1);
                enter = 1'b0;
                chk("R2 enter request state", st, 1);
                chk("R2 enter powerdown", pd, 3);
                chk("R7 run in entry request", run, 1);
                if (mode == 1) begin exitr = 1'b1; sel = 2'(s); end
                step(1);
                exitr = 1'b0;
                sel = 2'(s) ^ 2'd1;
                chk("R2 wait state", st, 2);
                if (mode == 2) begin exitr = 1'b1; sel = 2'(s); end
                status = 1'b1;
                step(1);
                exitr = 1'b0;
                sel = 2'(s) ^ 2'd1;
                step(1);
                chk("R3 still waiting", st, 2);
                chk("R7 run in wait", run, 1);
                step(1);
                chk("R3 reached P3", st, 3);
                chk("R4 run low in P3", run, 0);

                if (mode == 0) begin
                    enter = 1'b1;
                    step(1);
                    enter = 1'b0;
                    chk("R4 enter ignored in P3", st, 3);
                    chk("R4 pd in P3", pd, 3);
                    exitr = 1'b1; sel = 2'(s);
                    step(1);
                    exitr = 1'b0;
                    chk("R5 exit request state", st, 4);
                end else begin
                    step(1);
                    chk("R8 held exit proceeds", st, 4);
                end
                chk("R9 exit powerdown", pd, exp_pd);
                chk("R7 run in exit request", run, 0);

                enter = 1'b1;
                step(1);
                enter = 1'b0;
                chk("R5 exit wait state", st, 5);
                chk("R7 run in exit wait", run, 1);
                step(4);
                chk("R11 stale status level ignored", st, 5);
                chk("R10 enter ignored in exit wait", st, 5);
                exitr = 1'b1;
                step(1);
                exitr = 1'b0;
                chk("R10 exit ignored in exit wait", st, 5);

                status = 1'b0;
                step(3);
                status = 1'b1;
                step(2);
                chk("R6 still waiting for exit ack", st, 5);
                step(1);
                chk("R6 back to normal", st, 0);
                chk("R6 pd kept", pd, exp_pd);
                chk("R7 run in normal", run, 1);
                status = 1'b0;
                step(4);
                chk("R10 status fall in normal", st, 0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule